// File: doc/BRIEF.md
# Standby Controller with Counter Deadline

This block puts a core into low-power standby on behalf of its two wait instructions: an interrupt-wait and an event-wait. Each has an untimed form and a timed form. The timed form carries an absolute 64-bit value taken from a register. The core raises a one-cycle request and names the instruction kind and form. The controller then holds the core in standby until a wake condition arrives. It ends the wait with a one-cycle done pulse and a 2-bit wake cause.

There are three wake sources. Any pending interrupt line wakes either kind, with no regard to masking. An event wakes only the event-wait kind, either one arriving during standby or one already latched in a one-bit event register. A timeout ends a timed wait once a free-running 64-bit virtual counter is at or above the supplied deadline, compared unsigned. The counter may step by more than one per cycle, so the test never relies on equality. If a wake condition already holds when the request is taken, the instruction completes on the next cycle and standby is never entered.

Top module: `standby_ctrl`

## Requirements
- R1: After reset, standby_o and done_o are 0, cause_o is 00 and the event register is clear.
- R2: A request taken in idle with no wake condition holding raises standby_o from the next cycle until the cycle in which done_o rises.
- R3: While in standby, any set bit of irq_i wakes either kind on the next cycle with cause_o = 01, whatever the other bits are.
- R4: An event-wait in standby wakes on event_i with cause_o = 10. An interrupt-wait ignores events and stays in standby.
- R5: An event_i pulse sets the event register in any state. An event-wait requested while the register is set completes on the next cycle with cause_o = 10, without standby, and clears the register.
- R6: A timed wait wakes with cause_o = 11 once the counter is at or above the deadline latched at request time. The comparison is unsigned over all 64 bits and catches a counter that jumps past the deadline.
- R7: An untimed wait never wakes on the counter, whatever the deadline input holds.
- R8: A timed request whose deadline has already been reached completes on the next cycle with cause_o = 11, without standby.
- R9: done_o is high for exactly one cycle per wait. cause_o is non-zero only in that cycle, and the block returns to idle after it.
- R10: When several wake conditions hold in the same cycle, the cause is chosen in the order interrupt (01), then event (10), then timeout (11).
- R11: req_i is ignored while in standby and while done_o is high.
- R12: A wake by interrupt or timeout leaves the event register set if it was set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Wait instruction request, taken only in idle |
| evt_wait_i | input | 1 | 1 = event-wait, 0 = interrupt-wait |
| timed_i | input | 1 | 1 = timed form using deadline_i |
| deadline_i | input | CNT_W | Absolute counter deadline, latched with the request |
| vcnt_i | input | CNT_W | Free-running virtual counter |
| irq_i | input | NIRQ | Pending interrupt lines |
| event_i | input | 1 | Event arrival pulse |
| standby_o | output | 1 | Core held in standby |
| done_o | output | 1 | One-cycle completion pulse |
| cause_o | output | 2 | Wake cause: 01 interrupt, 10 event, 11 timeout, 00 none |

## Verification
The bench targets the boundaries of the deadline comparison. A deadline equal to the counter must wake at once. A deadline with its top bit set must stay pending against a counter just below the halfway point, which a signed compare would get wrong. A counter that jumps past the deadline must still wake, which an equality test would miss. It also checks the event register across instructions: an event seen during an interrupt-wait, or during a wait ended by an interrupt, must still make the next event-wait return at once. A design that cleared the register on every wake would sleep instead. Further checks cover simultaneous wake sources, where a wrong priority shows up as the wrong cause code, and requests raised during standby or on the done cycle, which a faulty controller would accept and so re-enter standby or change the instruction kind.

// File: rtl/standby_pkg.sv
package standby_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_IRQ  = 2'b01,
    CAUSE_EVT  = 2'b10,
    CAUSE_TMO  = 2'b11
  } wake_cause_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'b00,
    ST_STANDBY = 2'b01,
    ST_WAKE    = 2'b10
  } sb_state_e;

  typedef struct packed {
    logic evt_kind;
    logic timed;
  } wait_op_t;

endpackage

// File: rtl/standby_ge_cmp.sv
// Unsigned a >= b, split into chunks to keep the carry chain short.
module standby_ge_cmp #(
  parameter int unsigned W       = 64,
  parameter int unsigned CHUNK_W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         ge_o
);

  localparam int unsigned NCH   = (W + CHUNK_W - 1) / CHUNK_W;
  localparam int unsigned PAD_W = NCH * CHUNK_W;

  logic [PAD_W-1:0] a_pad;
  logic [PAD_W-1:0] b_pad;
  logic [NCH-1:0]   gt;
  logic [NCH-1:0]   eq;

  assign a_pad = PAD_W'(a_i);
  assign b_pad = PAD_W'(b_i);

  for (genvar g = 0; g < NCH; g++) begin : g_chunk
    assign gt[g] = a_pad[g*CHUNK_W +: CHUNK_W] >  b_pad[g*CHUNK_W +: CHUNK_W];
    assign eq[g] = a_pad[g*CHUNK_W +: CHUNK_W] == b_pad[g*CHUNK_W +: CHUNK_W];
  end

  // walk upward; the most significant unequal chunk decides
  always_comb begin
    ge_o = 1'b1;
    for (int i = 0; i < NCH; i++) begin
      if (gt[i])       ge_o = 1'b1;
      else if (!eq[i]) ge_o = 1'b0;
    end
  end

endmodule

// File: rtl/standby_evt_reg.sv
module standby_evt_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic event_i,
  input  logic consume_i,
  output logic evt_pend_o
);

  logic evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        evt_q <= 1'b0;
    else if (consume_i) evt_q <= 1'b0;
    else if (event_i)   evt_q <= 1'b1;
  end

  // an arriving event counts in the same cycle
  assign evt_pend_o = evt_q | event_i;

  a_r5_consume_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume_i |=> !evt_q);

  a_r5_event_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i && !consume_i) |=> evt_q);

endmodule

// File: rtl/standby_fsm.sv
module standby_fsm
  import standby_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  wait_op_t         op_i,
  input  logic [CNT_W-1:0] deadline_i,
  input  logic             irq_any_i,
  input  logic             evt_pend_i,
  input  logic             ge_i,
  output logic [CNT_W-1:0] ddl_sel_o,
  output logic             evt_consume_o,
  output logic             standby_o,
  output logic             done_o,
  output wake_cause_e      cause_o
);

  sb_state_e        state_q, state_d;
  wait_op_t         op_q, op_eff;
  logic [CNT_W-1:0] ddl_q;
  wake_cause_e      cause_q, cause_d, hit;
  logic             take;

  assign take = (state_q == ST_IDLE) && req_i;

  // in idle the request itself is evaluated, so a met condition skips standby
  always_comb begin
    op_eff    = (state_q == ST_IDLE) ? op_i : op_q;
    ddl_sel_o = (state_q == ST_IDLE) ? deadline_i : ddl_q;
  end

  always_comb begin
    if (irq_any_i)                          hit = CAUSE_IRQ;
    else if (op_eff.evt_kind && evt_pend_i) hit = CAUSE_EVT;
    else if (op_eff.timed && ge_i)          hit = CAUSE_TMO;
    else                                    hit = CAUSE_NONE;
  end

  always_comb begin
    state_d       = state_q;
    cause_d       = CAUSE_NONE;
    evt_consume_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          if (hit != CAUSE_NONE) begin
            state_d       = ST_WAKE;
            cause_d       = hit;
            evt_consume_o = (hit == CAUSE_EVT);
          end else begin
            state_d = ST_STANDBY;
          end
        end
      end
      ST_STANDBY: begin
        if (hit != CAUSE_NONE) begin
          state_d       = ST_WAKE;
          cause_d       = hit;
          evt_consume_o = (hit == CAUSE_EVT);
        end
      end
      ST_WAKE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cause_q <= CAUSE_NONE;
      op_q    <= '0;
      ddl_q   <= '0;
    end else begin
      state_q <= state_d;
      cause_q <= cause_d;
      if (take) begin
        op_q  <= op_i;
        ddl_q <= deadline_i;
      end
    end
  end

  assign standby_o = (state_q == ST_STANDBY);
  assign done_o    = (state_q == ST_WAKE);
  assign cause_o   = cause_q;

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_cause_only_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o == (cause_o != CAUSE_NONE)));

  a_r3_irq_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (standby_o && irq_any_i) |=> (done_o && cause_o == CAUSE_IRQ));

  a_r6_timeout_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (standby_o && op_q.timed && ge_i && !irq_any_i && !(op_q.evt_kind && evt_pend_i))
      |=> (done_o && cause_o == CAUSE_TMO));

  a_r7_untimed_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (standby_o && !op_q.timed && !irq_any_i && !(op_q.evt_kind && evt_pend_i))
      |=> standby_o);

  a_r11_standby_keeps_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (standby_o && $past(standby_o)) |-> $stable(op_q));

endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
  import standby_pkg::*;
#(
  parameter int unsigned CNT_W   = 64,
  parameter int unsigned NIRQ    = 8,
  parameter int unsigned CHUNK_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             evt_wait_i,
  input  logic             timed_i,
  input  logic [CNT_W-1:0] deadline_i,
  input  logic [CNT_W-1:0] vcnt_i,
  input  logic [NIRQ-1:0]  irq_i,
  input  logic             event_i,
  output logic             standby_o,
  output logic             done_o,
  output logic [1:0]       cause_o
);

  wait_op_t         op;
  logic [CNT_W-1:0] ddl_sel;
  logic             ge;
  logic             irq_any;
  logic             evt_pend;
  logic             evt_consume;
  wake_cause_e      cause;

  assign op.evt_kind = evt_wait_i;
  assign op.timed    = timed_i;
  assign irq_any     = |irq_i;  // no masking on the wake path

  standby_ge_cmp #(
    .W       (CNT_W),
    .CHUNK_W (CHUNK_W)
  ) i_cmp (
    .a_i  (vcnt_i),
    .b_i  (ddl_sel),
    .ge_o (ge)
  );

  standby_evt_reg i_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .event_i    (event_i),
    .consume_i  (evt_consume),
    .evt_pend_o (evt_pend)
  );

  standby_fsm #(
    .CNT_W (CNT_W)
  ) i_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_i         (req_i),
    .op_i          (op),
    .deadline_i    (deadline_i),
    .irq_any_i     (irq_any),
    .evt_pend_i    (evt_pend),
    .ge_i          (ge),
    .ddl_sel_o     (ddl_sel),
    .evt_consume_o (evt_consume),
    .standby_o     (standby_o),
    .done_o        (done_o),
    .cause_o       (cause)
  );

  assign cause_o = cause;

  a_r10_irq_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (standby_o && irq_any) |=> (cause_o == 2'b01));

endmodule

// File: tb/test_standby_ctrl.sv
module test_standby_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        kind = 1'b0;
  logic        timed = 1'b0;
  logic [63:0] ddl = '0;
  logic [63:0] cnt = '0;
  logic [7:0]  irq = '0;
  logic        evt = 1'b0;
  logic        standby, done;
  logic [1:0]  cause;

  int unsigned errors = 0;
  int unsigned checks = 0;
  int unsigned cyc = 0;
  int unsigned step = 1;
  bit          finished = 0;

  always #4 clk = ~clk;

  standby_ctrl i_standby_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .req_i      (req),
    .evt_wait_i (kind),
    .timed_i    (timed),
    .deadline_i (ddl),
    .vcnt_i     (cnt),
    .irq_i      (irq),
    .event_i    (evt),
    .standby_o  (standby),
    .done_o     (done),
    .cause_o    (cause)
  );

  // reference built from the requirements
  localparam int M_IDLE = 0, M_SB = 1, M_WK = 2;
  int          m_st;
  logic        m_evt, m_kind, m_timed;
  logic [63:0] m_ddl;
  logic [1:0]  m_cause;

  function automatic logic [1:0] m_hit(logic k, logic t, logic [63:0] d, logic evp);
    if (|irq)            return 2'b01;
    if (k && evp)        return 2'b10;
    if (t && (cnt >= d)) return 2'b11;
    return 2'b00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= M_IDLE; m_evt <= 1'b0; m_kind <= 1'b0; m_timed <= 1'b0;
      m_ddl <= '0; m_cause <= 2'b00;
    end else begin
      logic [1:0] h;
      logic       cons;
      cons = 1'b0;
      m_cause <= 2'b00;
      case (m_st)
        M_IDLE: if (req) begin
          m_kind <= kind; m_timed <= timed; m_ddl <= ddl;
          h = m_hit(kind, timed, ddl, m_evt | evt);
          if (h != 2'b00) begin m_st <= M_WK; m_cause <= h; cons = (h == 2'b10); end
          else m_st <= M_SB;
        end
        M_SB: begin
          h = m_hit(m_kind, m_timed, m_ddl, m_evt | evt);
          if (h != 2'b00) begin m_st <= M_WK; m_cause <= h; cons = (h == 2'b10); end
        end
        default: m_st <= M_IDLE;
      endcase
      if (cons)     m_evt <= 1'b0;
      else if (evt) m_evt <= 1'b1;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // advance one cycle, compare against reference, then move the counter
  task automatic tick();
    @(negedge clk);
    chk("R2 standby", standby, m_st == M_SB);
    chk("R9 done", done, m_st == M_WK);
    chk("R10 cause", cause, m_cause);
    cnt = cnt + 64'(step);
  endtask

  task automatic start(logic k, logic t, logic [63:0] d);
    req = 1'b1; kind = k; timed = t; ddl = d;
    tick();
    req = 1'b0;
  endtask

  task automatic wait_done(string tag, logic [1:0] exp_cause);
    bit seen = 0;
    for (int i = 0; i < 40 && !seen; i++) begin
      tick();
      if (done) seen = 1;
    end
    chk(tag, {seen, cause}, {1'b1, exp_cause});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 standby", standby, 1'b0);
    chk("R1 done", done, 1'b0);
    chk("R1 cause", cause, 2'b00);
    rst_n = 1'b1;
    cnt = 64'd1000; step = 1;
    tick();

    // R2 / R7: untimed interrupt-wait with a deadline already passed
    start(1'b0, 1'b0, 64'd0);
    chk("R2 enter standby", standby, 1'b1);
    repeat (5) tick();
    chk("R7 untimed ignores counter", standby, 1'b1);
    // R4: interrupt-wait ignores events
    evt = 1'b1; tick(); evt = 1'b0; tick();
    chk("R4 wfi ignores event", standby, 1'b1);
    // R3: any line wakes
    irq = 8'h20; tick(); irq = '0;
    chk("R3 irq wake done", done, 1'b1);
    chk("R3 irq cause 01", cause, 2'b01);
    tick();
    chk("R9 single pulse", done, 1'b0);
    chk("R9 back to idle", standby, 1'b0);

    // R12 / R5: event kept from before, consumed by event-wait
    start(1'b1, 1'b0, 64'd0);
    chk("R12 R5 immediate done", done, 1'b1);
    chk("R5 cause 10", cause, 2'b10);
    chk("R5 no standby", standby, 1'b0);
    tick();
    start(1'b1, 1'b0, 64'd0);
    chk("R5 register cleared", standby, 1'b1);
    repeat (3) tick();
    evt = 1'b1; tick(); evt = 1'b0;
    chk("R4 event wake", done, 1'b1);
    chk("R4 event cause 10", cause, 2'b10);
    tick();

    // R6: counter stepping by three crosses the deadline
    step = 3;
    start(1'b1, 1'b1, cnt + 64'd10);
    chk("R6 timed standby", standby, 1'b1);
    wait_done("R6 timeout cause 11", 2'b11);
    tick();
    // R6: unsigned compare near the top of the range
    step = 1;
    cnt = 64'h7FFF_FFFF_FFFF_FF00;
    start(1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFF0);
    repeat (5) tick();
    chk("R6 unsigned pending", standby, 1'b1);
    cnt = 64'hFFFF_FFFF_FFFF_FFF8;
    tick();
    chk("R6 jump past deadline", {done, cause}, {1'b1, 2'b11});
    cnt = 64'd2000;
    tick();

    // R8: deadline equal and below
    start(1'b0, 1'b1, cnt);
    chk("R8 equal deadline", {done, cause, standby}, {1'b1, 2'b11, 1'b0});
    tick();
    start(1'b1, 1'b1, cnt - 64'd5);
    chk("R8 past deadline", {done, cause, standby}, {1'b1, 2'b11, 1'b0});
    tick();

    // R10: simultaneous wake sources
    start(1'b1, 1'b1, cnt + 64'd1000);
    irq = 8'h01; evt = 1'b1; cnt = cnt + 64'd5000;
    tick();
    irq = '0; evt = 1'b0;
    chk("R10 irq beats event and timeout", cause, 2'b01);
    tick();
    start(1'b1, 1'b1, cnt - 64'd1);
    chk("R10 event beats timeout", cause, 2'b10);
    tick();

    // R11: requests in standby and on the done cycle
    start(1'b0, 1'b0, 64'd0);
    req = 1'b1; kind = 1'b1; tick(); req = 1'b0;
    chk("R11 req in standby ignored", standby, 1'b1);
    evt = 1'b1; tick(); evt = 1'b0;
    chk("R11 kind unchanged", standby, 1'b1);
    irq = 8'h80; tick(); irq = '0;
    chk("R11 wake", done, 1'b1);
    req = 1'b1; kind = 1'b0; timed = 1'b0; tick(); req = 1'b0;
    chk("R11 req on done ignored", {standby, done}, 2'b00);
    tick();

    // constrained random phase
    cnt = 64'h1000;
    for (int n = 0; n < 4000; n++) begin
      step = $urandom % 4;
      req   = ($urandom % 4) == 0;
      kind  = $urandom % 2;
      timed = $urandom % 2;
      ddl   = ($urandom % 4 != 0) ? cnt + 64'($urandom % 60) : {$urandom, $urandom};
      irq   = (($urandom % 30) == 0) ? 8'(1 << ($urandom % 8)) : '0;
      evt   = ($urandom % 20) == 0;
      tick();
    end
    req = 1'b0; irq = '0; evt = 1'b0;
    repeat (2) tick();

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule